// File: doc/BRIEF.md
# Partitioned 8x16 multiply unit

This block multiplies unsigned 8-bit values by signed 16-bit values in several lanes at once. Each lane keeps the middle sixteen bits of its product and rounds up on the bit just below them. A 3-bit variant code picks which bytes and which 16-bit multipliers are routed to the shared multiplier array. The code also picks how the rounded lane values are placed in the 64-bit result. A caller presents the variant code and two 64-bit operands with a one-cycle `in_valid` pulse. The result appears on the next cycle, marked by `out_valid`.

The output stage is a two-state machine. `ST_IDLE` means no result is being presented. `ST_OUT` means `result` carries the value captured at the last clock edge and `out_valid` is high. The transitions are named as follows. *Issue* (`ST_IDLE`→`ST_OUT`) and *stream* (`ST_OUT`→`ST_OUT`) are taken whenever `in_valid` is high. *Drain* (`ST_OUT`→`ST_IDLE`) and *rest* (`ST_IDLE`→`ST_IDLE`) are taken when it is low. Reset forces `ST_IDLE`.

Top module: `pmul8x16_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a clock edge that samples `in_valid` high, and low after an edge that samples it low.
- R2: Each lane forms the full product of an unsigned byte and a signed 16-bit multiplier. It takes product bits [23:8] and adds one when product bit 7 is set. The sum wraps modulo 2^16, so a product of -1 yields 0x0000.
- R3: Variant 0 (lane) multiplies byte i of `opa[31:0]` by 16-bit lane i of `opb`. Rounded lane i goes to `result[16i+15:16i]`, and `opa[63:32]` is ignored.
- R4: Variant 1 (scalar high) uses `opb[31:16]` as the multiplier for all four bytes of `opa[31:0]`. Variant 2 (scalar low) uses `opb[15:0]` instead. Output placement is as in R3, and `opb[63:32]` is ignored.
- R5: Variant 3 (byte high) multiplies bits [15:8] of each 16-bit lane of `opa` by the same lane of `opb`. Variant 4 (byte low) uses bits [7:0] of each lane instead. Placement is as in R3.
- R6: Variant 5 (wide high) and variant 6 (wide low) use only the two 16-bit halves of `opa[31:0]` and `opb[31:0]`. The byte is taken from bits [15:8] (high) or bits [7:0] (low) of each half. Rounded half i is placed at `result[32i+22:32i+7]`, and every other result bit is 0.
- R7: Variant 7 is reserved. It yields an all-zero result with `out_valid` still raised.
- R8: Reset clears `out_valid` and `result` to zero. While `in_valid` is low, `result` holds its last value, whatever the operands do.
- R9: Operations issued on consecutive cycles produce results on consecutive cycles, with `out_valid` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request for this cycle |
| variant | input | 3 | Variant code, 0 to 7 (see R3 to R7) |
| opa | input | 64 | Byte source operand |
| opb | input | 64 | Multiplier source operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Packed rounded lane results |

## Verification
A wrong stage state shows on `out_valid` at the very next edge. The state is the only source of the strobe, so a missed issue or a missed drain is visible in one cycle. A fault in operand routing, rounding or placement shows in `result` one cycle after the request. The bench uses vectors that give each variant a distinct answer, so a crossed mux leg changes at least one lane. Unused operand halves are loaded with junk in those vectors so that a stray read appears in the output. Holding behaviour is exposed by changing the operands while `in_valid` is low and confirming that `result` does not move.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [2:0] {
        VAR_LANE    = 3'd0,
        VAR_SCAL_HI = 3'd1,
        VAR_SCAL_LO = 3'd2,
        VAR_BYTE_HI = 3'd3,
        VAR_BYTE_LO = 3'd4,
        VAR_WIDE_HI = 3'd5,
        VAR_WIDE_LO = 3'd6,
        VAR_NONE    = 3'd7
    } variant_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } stage_e;

    function automatic logic is_wide(variant_e v);
        return (v == VAR_WIDE_HI) || (v == VAR_WIDE_LO);
    endfunction

endpackage

// File: rtl/pmul_opsel.sv
// Routes bytes and multipliers from the operands to each lane per variant.
module pmul_opsel
    import pmul_pkg::*;
#(
    parameter int BW    = 8,
    parameter int MW    = 16,
    parameter int LANES = 4
) (
    input  variant_e                     sel,
    input  logic [LANES*MW-1:0]          opa,
    input  logic [LANES*MW-1:0]          opb,
    output logic [LANES-1:0][BW-1:0]     mcand,
    output logic [LANES-1:0][MW-1:0]     mplier
);
    localparam int HALF = LANES / 2;

    always_comb begin
        mcand  = '0;
        mplier = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (sel)
                VAR_LANE: begin
                    mcand[i]  = opa[i*BW +: BW];
                    mplier[i] = opb[i*MW +: MW];
                end
                VAR_SCAL_HI: begin
                    mcand[i]  = opa[i*BW +: BW];
                    mplier[i] = opb[MW +: MW];
                end
                VAR_SCAL_LO: begin
                    mcand[i]  = opa[i*BW +: BW];
                    mplier[i] = opb[0 +: MW];
                end
                VAR_BYTE_HI: begin
                    mcand[i]  = opa[i*MW+BW +: BW];
                    mplier[i] = opb[i*MW +: MW];
                end
                VAR_BYTE_LO: begin
                    mcand[i]  = opa[i*MW +: BW];
                    mplier[i] = opb[i*MW +: MW];
                end
                VAR_WIDE_HI: begin
                    if (i < HALF) begin
                        mcand[i]  = opa[i*MW+BW +: BW];
                        mplier[i] = opb[i*MW +: MW];
                    end
                end
                VAR_WIDE_LO: begin
                    if (i < HALF) begin
                        mcand[i]  = opa[i*MW +: BW];
                        mplier[i] = opb[i*MW +: MW];
                    end
                end
                VAR_NONE: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane.sv
// One unsigned-by-signed multiplier with middle-bit extraction and round-up.
module pmul_lane #(
    parameter int BW = 8,
    parameter int MW = 16
) (
    input  logic [BW-1:0] mcand,
    input  logic [MW-1:0] mplier,
    output logic [MW-1:0] rounded
);
    localparam int PW = BW + MW;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;
    logic          unused_lsb;

    assign a_ext   = {{MW{1'b0}}, mcand};
    assign b_ext   = {{BW{mplier[MW-1]}}, mplier};
    assign prod    = a_ext * b_ext;
    assign rounded = prod[PW-1:BW] + {{(MW-1){1'b0}}, prod[BW-1]};
    assign unused_lsb = ^prod[BW-2:0];

endmodule

// File: rtl/pmul_place.sv
// Packs rounded lane values into the result word per variant.
module pmul_place
    import pmul_pkg::*;
#(
    parameter int BW    = 8,
    parameter int MW    = 16,
    parameter int LANES = 4
) (
    input  variant_e                 sel,
    input  logic [LANES-1:0][MW-1:0] lane_res,
    output logic [LANES*MW-1:0]      packed_res
);
    localparam int HALF = LANES / 2;

    always_comb begin
        packed_res = '0;
        if (is_wide(sel)) begin
            for (int i = 0; i < HALF; i++) begin
                packed_res[i*2*MW + BW-1 +: MW] = lane_res[i];
            end
        end else if (sel != VAR_NONE) begin
            for (int i = 0; i < LANES; i++) begin
                packed_res[i*MW +: MW] = lane_res[i];
            end
        end
    end

endmodule

// File: rtl/pmul8x16_unit.sv
module pmul8x16_unit
    import pmul_pkg::*;
#(
    parameter int BW    = 8,
    parameter int MW    = 16,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          variant,
    input  logic [LANES*MW-1:0] opa,
    input  logic [LANES*MW-1:0] opb,
    output logic                out_valid,
    output logic [LANES*MW-1:0] result
);
    localparam int DW   = LANES * MW;
    localparam int HALF = LANES / 2;

    variant_e                 sel_v;
    logic [LANES-1:0][BW-1:0] mcand;
    logic [LANES-1:0][MW-1:0] mplier;
    logic [LANES-1:0][MW-1:0] lane_res;
    logic [DW-1:0]            placed;
    stage_e                   state;
    stage_e                   state_nxt;

    assign sel_v = variant_e'(variant);

    pmul_opsel #(.BW(BW), .MW(MW), .LANES(LANES)) u_opsel (
        .sel    (sel_v),
        .opa    (opa),
        .opb    (opb),
        .mcand  (mcand),
        .mplier (mplier)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane #(.BW(BW), .MW(MW)) u_lane (
            .mcand   (mcand[g]),
            .mplier  (mplier[g]),
            .rounded (lane_res[g])
        );
    end

    pmul_place #(.BW(BW), .MW(MW), .LANES(LANES)) u_place (
        .sel        (sel_v),
        .lane_res   (lane_res),
        .packed_res (placed)
    );

    // Stage state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_OUT : ST_IDLE; // issue / rest
            ST_OUT:  state_nxt = in_valid ? ST_OUT : ST_IDLE; // stream / drain
        endcase
    end

    // Result capture
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= placed;
    end

    // Outputs from state
    always_comb begin
        out_valid = (state == ST_OUT);
    end

    // Bits that a wide variant may write
    logic [DW-1:0] wide_keep;
    always_comb begin
        wide_keep = '0;
        for (int i = 0; i < HALF; i++) begin
            wide_keep[i*2*MW + BW-1 +: MW] = '1;
        end
    end

    p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    p_wide_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_wide(sel_v)) |=> ((result & ~wide_keep) == '0));
    p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_v == VAR_NONE) |=> (result == '0));
    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_v == VAR_SCAL_HI || sel_v == VAR_SCAL_LO) |-> (mplier[0] == mplier[LANES-1]));

endmodule

// File: tb/test_pmul8x16_unit.sv
module test_pmul8x16_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [2:0]  v;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 64'h0000_0000_FF80_0201, 64'h7FFF_FF00_0080_0100, 64'h7F7F_FF80_0001_0001},
        '{3'd0, 64'h0000_0000_0301_0101, 64'h0055_FFFF_007F_0080, 64'h0001_0000_0000_0001},
        '{3'd1, 64'hFF00_2010_FF00_2010, 64'hDEAD_BEEF_0100_1234, 64'h00FF_0000_0020_0010},
        '{3'd2, 64'h0000_0000_FF00_2010, 64'hDEAD_BEEF_1234_FFFE, 64'hFFFE_0000_0000_0000},
        '{3'd3, 64'h0402_0301_0200_01FF, 64'h0100_0100_0100_0100, 64'h0004_0003_0002_0001},
        '{3'd4, 64'h0402_0301_0200_01FF, 64'h0100_0100_0100_0100, 64'h0002_0001_0000_00FF},
        '{3'd5, 64'hAAAA_AAAA_0302_0180, 64'h5555_5555_FF00_0200, 64'h007F_FE80_0000_0100},
        '{3'd6, 64'hAAAA_AAAA_0302_0180, 64'h5555_5555_FF00_0200, 64'h007F_FF00_0000_8000},
        '{3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0000_0000_0000_0000},
        '{3'd0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  variant;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [63:0] result;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    string tags [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmul8x16_unit i_pmul8x16_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .variant   (variant),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic vld, input logic [2:0] v, input logic [63:0] a, input logic [63:0] b);
        in_valid = vld;
        variant  = v;
        opa      = a;
        opb      = b;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tags[0] = "R3 lane variant";
        tags[1] = "R2 round-up and wrap";
        tags[2] = "R4 scalar high";
        tags[3] = "R4 scalar low with R2 wrap";
        tags[4] = "R5 byte high";
        tags[5] = "R5 byte low";
        tags[6] = "R6 wide high";
        tags[7] = "R6 wide low";
        tags[8] = "R7 reserved code";
        tags[9] = "R3 upper opa ignored";

        rst_n = 1'b0;
        drive(1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
        repeat (3) @(negedge clk);
        chk("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R8 reset result", result, 64'd0);
        rst_n = 1'b1;
        drive(1'b0, 3'd0, 64'd0, 64'd0);
        @(negedge clk);

        // Table walk: one issue, one check per vector
        for (int k = 0; k < NV; k++) begin
            drive(1'b1, VECS[k].v, VECS[k].a, VECS[k].b);
            @(negedge clk);
            chk({tags[k], " (R1 strobe)"}, {63'd0, out_valid}, 64'd1);
            chk(tags[k], result, VECS[k].exp);
            drive(1'b0, 3'd0, 64'd0, 64'd0);
            @(negedge clk);
        end

        // Hold: result keeps last value while operands change with in_valid low
        drive(1'b1, VECS[0].v, VECS[0].a, VECS[0].b);
        @(negedge clk);
        drive(1'b0, 3'd1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        @(negedge clk);
        chk("R1 drain out_valid", {63'd0, out_valid}, 64'd0);
        chk("R8 hold result", result, VECS[0].exp);
        @(negedge clk);
        chk("R8 hold second cycle", result, VECS[0].exp);

        // Back-to-back issue
        drive(1'b1, VECS[4].v, VECS[4].a, VECS[4].b);
        @(negedge clk);
        chk("R9 first of pair", result, VECS[4].exp);
        drive(1'b1, VECS[6].v, VECS[6].a, VECS[6].b);
        @(negedge clk);
        chk("R9 stream out_valid", {63'd0, out_valid}, 64'd1);
        chk("R9 second of pair", result, VECS[6].exp);
        drive(1'b0, 3'd0, 64'd0, 64'd0);

        // Reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R8 mid reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule